// File: doc/BRIEF.md
# Oversampled UART Receiver with DMA Handshake

This block is the receive half of an asynchronous serial port. It watches a serial line at sixteen times the bit rate, recovers one frame at a time (a low start bit, eight data bits sent least significant first, and a high stop bit) and places the byte in a single data register. A ready flag shows that a byte is waiting. When DMA mode is on, a request line follows that flag. Any read of the data register clears both, whether the read comes from a processor or from a DMA engine. Framing, noise and overrun errors are latched as sticky flags. They feed an error interrupt that has its own enable, separate from the data-ready interrupt.

Two flow-control helpers sit beside the receiver. The first drives a request-to-send output that tells the far end to hold off while a byte is waiting unread. The second produces a transmit-start permission, gated by a synchronized clear-to-send input, for a neighbouring transmitter. Each helper has its own enable. The bit rate comes from a fixed divisor input that sets how many clocks make up one oversample tick.

Top module: `uart_rx_dma`

## Requirements
- R1: One oversample tick occurs every `baud_div` clocks (a value of 0 behaves as 1), and a bit lasts 16 ticks. Frame format: a low start bit, 8 data bits sent LSB first, and a high stop bit. When a frame ends, `rd_data` holds the byte and `rx_ready` is 1.
- R2: A one-cycle pulse on `rd_en` clears `rx_ready` on the next clock edge.
- R3: `dma_req` is 1 exactly while `dma_en` is 1 and a byte is waiting. It is raised once per received frame and dropped by the read. With `dma_en` at 0 it stays 0.
- R4: Each bit is decided by a majority of three samples taken at ticks 7, 8 and 9 of that bit. A single disturbed sample does not change the byte, but it sets `err_noise` together with `rx_ready`.
- R5: A stop bit whose majority is 0 sets `err_frame` in the same cycle as `rx_ready`, and the byte is still delivered.
- R6: A frame that completes while `rx_ready` is still 1 (and no read is in that cycle) sets `err_overrun`. The new byte is dropped and `rd_data` keeps the old byte.
- R7: A pulse on `err_clr` clears all three error flags and leaves `rx_ready` and `rd_data` unchanged.
- R8: `irq_rx` = `rxne_ie` AND `rx_ready`. `irq_err` = `err_ie` AND (any error flag). Each enable acts only on its own output.
- R9: With `rts_en` at 1, `rts_n` is 0 while the data register is empty and 1 while a byte is waiting unread. With `rts_en` at 0, `rts_n` is 0.
- R10: `tx_go` is 1 only while `tx_pending` is 1 and `tx_busy` is 0, and also either `cts_en` is 0 or `cts_n` has been low through a two-flop synchronizer (two clock edges). A frame already started is governed by `tx_busy` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 16 | Clocks per oversample tick |
| rx_in | input | 1 | Serial receive line (idle high) |
| dma_en | input | 1 | Enable DMA request line |
| rxne_ie | input | 1 | Enable data-ready interrupt |
| err_ie | input | 1 | Enable error interrupt |
| rts_en | input | 1 | Enable request-to-send flow control |
| cts_en | input | 1 | Enable clear-to-send gating of transmit start |
| rd_en | input | 1 | Data register read strobe (processor or DMA) |
| err_clr | input | 1 | Write-one pulse clearing the error flags |
| cts_n | input | 1 | Clear-to-send from far end, active low |
| tx_pending | input | 1 | Transmitter has a frame to start |
| tx_busy | input | 1 | Transmitter frame in progress |
| rd_data | output | 8 | Received byte |
| rx_ready | output | 1 | A byte is waiting unread |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |
| err_noise | output | 1 | Noise flag |
| dma_req | output | 1 | DMA request |
| irq_rx | output | 1 | Data-ready interrupt |
| irq_err | output | 1 | Error interrupt |
| rts_n | output | 1 | Request-to-send, active low |
| tx_go | output | 1 | Permission for transmitter to start a frame |

## Verification
All 256 byte values are sent as clean frames, each followed by a read. This separates a wrong bit order or a lost bit from correct assembly, and it shows that the ready flag, the request line and request-to-send all rise with every byte and fall with every read. A one-sample glitch is then placed on each of the ten bit positions in turn, start and stop included. A faulty vote would change the byte, and a missing disagreement check would leave the noise flag clear. Further frames cover a low stop bit, a second frame sent without a read, interrupt enables turned off, and a second divisor value. A short handshake sequence separates clear-to-send gating from busy gating.

// File: rtl/uart_rx_pkg.sv
// Shared definitions for the oversampled UART receiver.
// Assumes: a frame is one start bit, DATA_W data bits and one stop bit.
package uart_rx_pkg;
    localparam int UART_DATA_W = 8;
    localparam int UART_OVS    = 16;
    localparam int UART_DIV_W  = 16;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/uart_rx_tick.sv
// Oversample tick generator: emits one tick every baud_div clocks.
// Assumes: baud_div is static while receiving; 0 is treated as 1.
module uart_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   cnt_nxt;

    // Next count value and end-of-period detection.
    always_comb begin
        cnt_nxt = {1'b0, cnt_q} + (DIV_W+1)'(1);
        tick    = (cnt_nxt >= {1'b0, baud_div});
    end

    // Divider counter, wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_nxt[DIV_W-1:0];
    end
endmodule

// File: rtl/uart_rx_frame.sv
// Frame engine: finds the start edge, votes three mid-bit samples per bit,
// shifts data LSB first and reports one completed frame with its status.
// Assumes: rx is already synchronized; OVS is a power of two, at least 8.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ferr,
    output logic              noise
);
    localparam int CNT_W  = $clog2(OVS);
    localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0]  SMP_A    = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0]  SMP_B    = CNT_W'(OVS/2);
    localparam logic [CNT_W-1:0]  SMP_C    = CNT_W'(OVS/2 + 1);
    localparam logic [CNT_W-1:0]  BIT_END  = CNT_W'(OVS - 1);
    localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(DATA_W - 1);

    rx_state_e         st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIDX_W-1:0] bidx_q;
    logic [DATA_W-1:0] shift_q;
    logic [1:0]        smp_q;
    logic              noisy_q;
    logic              vote;
    logic              disagree;

    // Majority of the two stored samples and the live third one.
    always_comb begin
        vote     = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx) | (smp_q[0] & rx);
        disagree = !((smp_q[1] == smp_q[0]) && (smp_q[0] == rx));
    end

    // Receive state machine, advanced on oversample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            bidx_q  <= '0;
            shift_q <= '0;
            smp_q   <= 2'b11;
            noisy_q <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
            ferr    <= 1'b0;
            noise   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (st_q == RX_IDLE) begin
                    if (!rx) begin
                        st_q    <= RX_START;
                        cnt_q   <= CNT_W'(1);
                        noisy_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == SMP_A) smp_q[1] <= rx;
                    if (cnt_q == SMP_B) smp_q[0] <= rx;
                    if (cnt_q == SMP_C) begin
                        noisy_q <= noisy_q | disagree;
                        case (st_q)
                            RX_START: if (vote) st_q <= RX_IDLE;
                            RX_DATA:  shift_q <= {vote, shift_q[DATA_W-1:1]};
                            RX_STOP: begin
                                done  <= 1'b1;
                                data  <= shift_q;
                                ferr  <= !vote;
                                noise <= noisy_q | disagree;
                                st_q  <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt_q == BIT_END) begin
                        if (st_q == RX_START) begin
                            st_q   <= RX_DATA;
                            bidx_q <= '0;
                        end else if (st_q == RX_DATA) begin
                            bidx_q <= bidx_q + BIDX_W'(1);
                            if (bidx_q == LAST_BIT) st_q <= RX_STOP;
                        end
                    end
                end
            end
        end
    end

    // A frame is reported once, and the engine is then back at idle.
    assert_single_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st_q == RX_IDLE));
endmodule

// File: rtl/uart_rx_regs.sv
// Data register and flags: accepts a finished frame, tracks ready,
// latches sticky framing/noise/overrun errors and handles read/clear.
// Assumes: rd_en and err_clr are single-cycle strobes.
module uart_rx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_ferr,
    input  logic              frame_noise,
    input  logic              rd_en,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data_q,
    output logic              rxne_q,
    output logic              fe_q,
    output logic              ore_q,
    output logic              nf_q
);
    logic accept;
    logic overrun;

    // A frame is taken if the register is free or being read this cycle.
    always_comb begin
        accept  = frame_done && (!rxne_q || rd_en);
        overrun = frame_done && rxne_q && !rd_en;
    end

    // Data register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            rxne_q <= 1'b0;
        end else if (accept) begin
            data_q <= frame_data;
            rxne_q <= 1'b1;
        end else if (rd_en) begin
            rxne_q <= 1'b0;
        end
    end

    // Sticky error flags: a new error wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q  <= 1'b0;
            ore_q <= 1'b0;
            nf_q  <= 1'b0;
        end else begin
            fe_q  <= (accept && frame_ferr)  || (fe_q  && !err_clr);
            nf_q  <= (accept && frame_noise) || (nf_q  && !err_clr);
            ore_q <= overrun                 || (ore_q && !err_clr);
        end
    end

    assert_ready_after_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rxne_q);
    assert_read_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !frame_done) |=> !rxne_q);
    assert_overrun_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rxne_q && !rd_en) |=> (ore_q && $stable(data_q)));
    assert_clear_keeps_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !frame_done && !rd_en) |=> ($stable(rxne_q) && !fe_q && !nf_q && !ore_q));
endmodule

// File: rtl/uart_flow_ctl.sv
// Flow control: request-to-send from receive occupancy and a
// clear-to-send gated start permission for a neighbouring transmitter.
// Assumes: cts_n is asynchronous; tx_busy covers a frame in progress.
module uart_flow_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_en,
    input  logic rx_full,
    input  logic cts_en,
    input  logic cts_n,
    input  logic tx_pending,
    input  logic tx_busy,
    output logic rts_n,
    output logic tx_go
);
    logic cts_s1_q;
    logic cts_s2_q;

    // Two-flop synchronizer for clear-to-send, reset to deasserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_s1_q <= 1'b1;
            cts_s2_q <= 1'b1;
        end else begin
            cts_s1_q <= cts_n;
            cts_s2_q <= cts_s1_q;
        end
    end

    // Output decode for both flow-control helpers.
    always_comb begin
        rts_n = rts_en && rx_full;
        tx_go = tx_pending && !tx_busy && (!cts_en || !cts_s2_q);
    end

    assert_cts_gates_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && cts_en) |-> ($past(cts_n, 2) == 1'b0));
endmodule

// File: rtl/uart_rx_dma.sv
// Top: UART receive path with DMA request, interrupts and flow control.
// Assumes: rx_in and cts_n are asynchronous; other inputs are synchronous.
module uart_rx_dma
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = UART_DATA_W,
    parameter int OVS    = UART_OVS,
    parameter int DIV_W  = UART_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              rx_in,
    input  logic              dma_en,
    input  logic              rxne_ie,
    input  logic              err_ie,
    input  logic              rts_en,
    input  logic              cts_en,
    input  logic              rd_en,
    input  logic              err_clr,
    input  logic              cts_n,
    input  logic              tx_pending,
    input  logic              tx_busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              err_noise,
    output logic              dma_req,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              rts_n,
    output logic              tx_go
);
    logic              rx_s1_q;
    logic              rx_s2_q;
    logic              tick;
    logic              f_done;
    logic [DATA_W-1:0] f_data;
    logic              f_ferr;
    logic              f_noise;

    // Two-flop synchronizer for the serial line, reset to idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_s1_q <= 1'b1;
            rx_s2_q <= 1'b1;
        end else begin
            rx_s1_q <= rx_in;
            rx_s2_q <= rx_s1_q;
        end
    end

    uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tick(tick)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s2_q),
        .done(f_done), .data(f_data), .ferr(f_ferr), .noise(f_noise)
    );

    uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .frame_done(f_done), .frame_data(f_data),
        .frame_ferr(f_ferr), .frame_noise(f_noise),
        .rd_en(rd_en), .err_clr(err_clr),
        .data_q(rd_data), .rxne_q(rx_ready),
        .fe_q(err_frame), .ore_q(err_overrun), .nf_q(err_noise)
    );

    uart_flow_ctl u_flow (
        .clk(clk), .rst_n(rst_n),
        .rts_en(rts_en), .rx_full(rx_ready),
        .cts_en(cts_en), .cts_n(cts_n),
        .tx_pending(tx_pending), .tx_busy(tx_busy),
        .rts_n(rts_n), .tx_go(tx_go)
    );

    // Request and interrupt outputs.
    always_comb begin
        dma_req = dma_en && rx_ready;
        irq_rx  = rxne_ie && rx_ready;
        irq_err = err_ie && (err_frame || err_overrun || err_noise);
    end

    assert_dma_on_new_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && $rose(rx_ready)) |-> dma_req);
    assert_err_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ie && $rose(err_frame)) |-> irq_err);
    assert_rts_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_en && rx_ready) |-> rts_n);
endmodule

// File: tb/uart_rx_dma_test.sv
// Self-checking bench: byte sweep, glitch sweep, error and handshake cases.
module uart_rx_dma_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] baud_div;
    logic        rx_in, dma_en, rxne_ie, err_ie, rts_en, cts_en;
    logic        rd_en, err_clr, cts_n, tx_pending, tx_busy;
    logic [7:0]  rd_data;
    logic        rx_ready, err_frame, err_overrun, err_noise;
    logic        dma_req, irq_rx, irq_err, rts_n, tx_go;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    uart_rx_dma uut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_in(rx_in),
        .dma_en(dma_en), .rxne_ie(rxne_ie), .err_ie(err_ie),
        .rts_en(rts_en), .cts_en(cts_en), .rd_en(rd_en), .err_clr(err_clr),
        .cts_n(cts_n), .tx_pending(tx_pending), .tx_busy(tx_busy),
        .rd_data(rd_data), .rx_ready(rx_ready), .err_frame(err_frame),
        .err_overrun(err_overrun), .err_noise(err_noise), .dma_req(dma_req),
        .irq_rx(irq_rx), .irq_err(irq_err), .rts_n(rts_n), .tx_go(tx_go)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one frame; glitch_pos 0..9 flips one mid-bit sample of that bit.
    task automatic send_frame(input logic [7:0] b, input logic stop, input int glitch_pos);
        int bit_clks = 16 * int'(baud_div);
        for (int p = 0; p < 10; p++) begin
            logic v = (p == 0) ? 1'b0 : ((p == 9) ? stop : b[p-1]);
            int len = (p == 9 && !stop) ? (bit_clks * 3) / 4 : bit_clks;
            rx_in = v;
            if (p == glitch_pos) begin
                ticks(bit_clks / 2);
                rx_in = ~v;
                ticks(int'(baud_div));
                rx_in = v;
                ticks(len - bit_clks / 2 - int'(baud_div));
            end else begin
                ticks(len);
            end
        end
        rx_in = 1'b1;
        ticks(bit_clks + 8);
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        ticks(1);
        rd_en = 1'b0;
    endtask

    task automatic do_clear();
        err_clr = 1'b1;
        ticks(1);
        err_clr = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        summary();
    end

    initial begin
        rst_n = 1'b0; baud_div = 16'd2; rx_in = 1'b1;
        dma_en = 0; rxne_ie = 0; err_ie = 0; rts_en = 0; cts_en = 0;
        rd_en = 0; err_clr = 0; cts_n = 1'b1; tx_pending = 0; tx_busy = 0;
        ticks(5);
        rst_n = 1'b1;
        ticks(2);

        // Reset state
        chk("R1 reset ready", rx_ready, 0);
        chk("R3 reset dma", dma_req, 0);
        chk("R7 reset flags", {err_frame, err_overrun, err_noise}, 0);
        chk("R8 reset irq", {irq_rx, irq_err}, 0);
        chk("R9 reset rts", rts_n, 0);
        chk("R10 reset go", tx_go, 0);

        dma_en = 1; rxne_ie = 1; err_ie = 1; rts_en = 1;

        // R1/R2/R3/R9: full byte sweep with a read after each frame
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b1, -1);
            chk("R1 data", rd_data, b);
            chk("R1 ready", rx_ready, 1);
            chk("R3 dma up", dma_req, 1);
            chk("R9 rts full", rts_n, 1);
            chk("R8 irq_rx", irq_rx, 1);
            chk("R4 R5 clean flags", {err_frame, err_overrun, err_noise, irq_err}, 0);
            do_read();
            chk("R2 read clears", rx_ready, 0);
            chk("R3 dma down", dma_req, 0);
            chk("R9 rts empty", rts_n, 0);
        end

        // R4: one-sample glitch on each bit position
        for (int p = 0; p < 10; p++) begin
            send_frame(8'hA5, 1'b1, p);
            chk("R4 vote data", rd_data, 8'hA5);
            chk("R4 noise flag", err_noise, 1);
            chk("R4 no frame err", err_frame, 0);
            chk("R8 irq_err on noise", irq_err, 1);
            do_read();
            do_clear();
            chk("R7 noise cleared", err_noise, 0);
        end

        // R5/R7: low stop bit, then clear leaves ready alone
        send_frame(8'h3C, 1'b0, -1);
        chk("R5 frame err", err_frame, 1);
        chk("R5 ready with err", rx_ready, 1);
        chk("R5 data kept", rd_data, 8'h3C);
        do_clear();
        chk("R7 frame err cleared", err_frame, 0);
        chk("R7 ready untouched", rx_ready, 1);
        chk("R7 data untouched", rd_data, 8'h3C);
        chk("R8 irq_err low", irq_err, 0);
        do_read();

        // R6: overrun keeps the first byte
        send_frame(8'h11, 1'b1, -1);
        send_frame(8'h22, 1'b1, -1);
        chk("R6 overrun flag", err_overrun, 1);
        chk("R6 old data kept", rd_data, 8'h11);
        chk("R6 still ready", rx_ready, 1);
        chk("R8 irq_err overrun", irq_err, 1);
        do_read();
        chk("R2 ready cleared", rx_ready, 0);
        do_clear();
        chk("R7 overrun cleared", err_overrun, 0);

        // R3/R8/R9: enables off
        dma_en = 0; rxne_ie = 0; err_ie = 0; rts_en = 0;
        send_frame(8'h5A, 1'b0, -1);
        chk("R5 frame err again", err_frame, 1);
        chk("R3 dma disabled", dma_req, 0);
        chk("R8 irq_rx disabled", irq_rx, 0);
        chk("R8 irq_err disabled", irq_err, 0);
        chk("R9 rts disabled", rts_n, 0);
        err_ie = 1;
        ticks(1);
        chk("R8 irq_err independent", {irq_err, irq_rx}, 2);
        do_read();
        do_clear();
        err_ie = 0;

        // R1: second divisor value
        baud_div = 16'd4;
        ticks(8);
        send_frame(8'hC3, 1'b1, -1);
        chk("R1 div4 data", rd_data, 8'hC3);
        chk("R1 div4 ready", rx_ready, 1);
        chk("R4 div4 clean", err_noise, 0);
        do_read();

        // R10: clear-to-send gating
        tx_pending = 1; cts_en = 1; cts_n = 1'b1;
        ticks(3);
        chk("R10 blocked by cts", tx_go, 0);
        cts_n = 1'b0;
        ticks(1);
        chk("R10 sync delay", tx_go, 0);
        ticks(1);
        chk("R10 cts allows", tx_go, 1);
        tx_busy = 1;
        ticks(1);
        chk("R10 busy blocks", tx_go, 0);
        tx_busy = 0; tx_pending = 0;
        ticks(1);
        chk("R10 nothing pending", tx_go, 0);
        cts_en = 0; cts_n = 1'b1; tx_pending = 1;
        ticks(1);
        chk("R10 cts disabled", tx_go, 1);
        tx_pending = 0;
        ticks(2);

        summary();
    end
endmodule